// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits beside an 8-bit CPU that has a 16-bit local address bus. It holds one 8-bit output register that software writes with an I/O write. The low seven bits of that register extend each CPU memory address to a 24-bit system address. The top bit takes the boot ROM and the onboard scratch RAM out of the memory map.

In every cycle the block turns the current CPU request into a system address and one of four chip selects:

- **boot ROM**: 1 KB at 0xF000.
- **onboard scratch RAM**: 1 KB at a parameterised base, 0xF400 by default.
- **common memory**: the top 16 KB, 0xC000–0xFFFF. This region never responds to the bank bits.
- **banked external memory**: everything below 0xC000.

The register clears on reset, so the CPU always starts from the boot ROM. Boot code can then copy itself to RAM, set the ROM-off bit and use the whole 64 KB as RAM. Once banking is in use, code and stacks stay in common memory while the bank bits change.

Top module: `bank_map_ctrl`

## Requirements
- R1: While `rst_n` is low, the bank register is cleared to 0x00 at once. After release it stays 0x00 until software writes it, so a memory read at 0xF000 asserts `rom_cs` and `sys_addr[22:16]` is 0.
- R2: The register loads `io_data` when `io_wr` is high at a rising clock edge and `cpu_addr[7:0]` equals `PORT_ADDR` (default 0x40). The new value governs every cycle after that edge. An I/O write to any other port leaves the register unchanged.
- R3: `sys_addr[15:0]` equals `cpu_addr`, and `sys_addr[22:16]` equals register bits 6..0.
- R4: `sys_addr[23]` is always 0, including while register bit 7 is 1.
- R5: With register bit 7 at 0, a memory request in 0xF000–0xF3FF asserts `rom_cs` only.
- R6: With register bit 7 at 1, `rom_cs` never asserts. A request at 0xF000 then asserts `common_cs`.
- R7: With bit 7 at 0, a memory request in the onboard RAM window (0xF400–0xF7FF by default) asserts `sram_cs`. With bit 7 at 1, `sram_cs` never asserts and the request goes to `common_cs`.
- R8: Priority is ROM first, then onboard RAM, then common or banked memory. Exactly one select asserts for each memory request.
- R9: A memory request in 0xC000–0xFFFF that neither the ROM nor the onboard RAM claims asserts `common_cs`. `banked_cs` never asserts in that range, whatever the bank value.
- R10: A memory request below 0xC000 asserts `banked_cs`.
- R11: When `mem_req` is low, all four selects are low. This covers idle cycles and I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised to `clk` |
| cpu_addr | input | 16 | CPU address; bits 7..0 carry the port number during I/O |
| mem_req | input | 1 | High during a memory read or write cycle |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_data | input | 8 | Data written by the CPU on an I/O write |
| sys_addr | output | 24 | Extended system address |
| rom_cs | output | 1 | Boot ROM select |
| sram_cs | output | 1 | Onboard scratch RAM select |
| common_cs | output | 1 | Common (unbanked) memory select |
| banked_cs | output | 1 | Banked external memory select |

## Verification
The hardest case to reach from the ports is the ROM window seen with the ROM-off bit set. From the ports, a ROM-off write followed by a fetch at 0xF000 looks the same as a missing ROM select, unless the test also proves that the fetch landed in common memory. The bench therefore first writes the ROM-off bit. It then probes the exact edges of the ROM and RAM windows, and repeats them after clearing the bit. Common-window stability is shown by sweeping many bank values and checking that the select for fixed addresses between 0xC000 and 0xFFFF never changes.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int CPU_AW   = 16;
  localparam int BANK_W   = 8;
  localparam int EXT_W    = BANK_W - 1;
  localparam int SYS_AW   = CPU_AW + BANK_W;

  typedef struct packed {
    logic             rom_off;
    logic [EXT_W-1:0] ext;
  } bank_t;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_ROM    = 3'd1,
    TGT_SRAM   = 3'd2,
    TGT_COMMON = 3'd3,
    TGT_BANKED = 3'd4
  } target_e;
endpackage

// File: rtl/bmm_rst_sync.sv
module bmm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bmm_bank_reg.sv
module bmm_bank_reg
  import bmm_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        port,
  input  logic [BANK_W-1:0] wr_data,
  output bank_t             bank_q
);
  logic  load_en;
  bank_t bank_d;

  assign load_en = io_wr && (port == PORT_ADDR);

  always_comb begin
    bank_d = bank_q;
    if (load_en) bank_d = bank_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (load_en) bank_q <= bank_d;
  end
endmodule

// File: rtl/bmm_win_match.sv
module bmm_win_match
  import bmm_pkg::*;
#(
  parameter logic [CPU_AW-1:0] BASE      = 16'hF000,
  parameter int                SPAN_LOG2 = 10,
  localparam int               TAG_W     = CPU_AW - SPAN_LOG2
) (
  input  logic [TAG_W-1:0] addr_tag,
  output logic             hit
);
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[CPU_AW-1:SPAN_LOG2];
  assign hit = (addr_tag == BASE_TAG);
endmodule

// File: rtl/bmm_decode.sv
module bmm_decode
  import bmm_pkg::*;
#(
  parameter logic [CPU_AW-1:0] ROM_BASE    = 16'hF000,
  parameter logic [CPU_AW-1:0] SRAM_BASE   = 16'hF400,
  parameter int                WIN_LOG2    = 10,
  parameter logic [CPU_AW-1:0] COMMON_BASE = 16'hC000,
  parameter int                COMMON_LOG2 = 14
) (
  input  logic              mem_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              rom_off,
  output target_e           target
);
  localparam int NWIN = 3;
  localparam logic [NWIN*CPU_AW-1:0] BASES = {COMMON_BASE, SRAM_BASE, ROM_BASE};
  localparam int SPANS [NWIN] = '{WIN_LOG2, WIN_LOG2, COMMON_LOG2};

  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    bmm_win_match #(
      .BASE      (BASES[w*CPU_AW +: CPU_AW]),
      .SPAN_LOG2 (SPANS[w])
    ) win_i (
      .addr_tag (cpu_addr[CPU_AW-1:SPANS[w]]),
      .hit      (hit[w])
    );
  end

  always_comb begin
    target = TGT_NONE;
    if (mem_req) begin
      if (!rom_off && hit[0])      target = TGT_ROM;
      else if (!rom_off && hit[1]) target = TGT_SRAM;
      else if (hit[2])             target = TGT_COMMON;
      else                         target = TGT_BANKED;
    end
  end
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmm_pkg::*;
#(
  parameter logic [7:0]        PORT_ADDR   = 8'h40,
  parameter logic [CPU_AW-1:0] ROM_BASE    = 16'hF000,
  parameter logic [CPU_AW-1:0] SRAM_BASE   = 16'hF400,
  parameter int                WIN_LOG2    = 10,
  parameter logic [CPU_AW-1:0] COMMON_BASE = 16'hC000,
  parameter int                COMMON_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              mem_req,
  input  logic              io_wr,
  input  logic [BANK_W-1:0] io_data,
  output logic [SYS_AW-1:0] sys_addr,
  output logic              rom_cs,
  output logic              sram_cs,
  output logic              common_cs,
  output logic              banked_cs
);
  logic    rst_sync_n;
  bank_t   bank_q;
  target_e target;

  bmm_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bmm_bank_reg #(.PORT_ADDR(PORT_ADDR)) reg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .io_wr   (io_wr),
    .port    (cpu_addr[7:0]),
    .wr_data (io_data),
    .bank_q  (bank_q)
  );

  bmm_decode #(
    .ROM_BASE    (ROM_BASE),
    .SRAM_BASE   (SRAM_BASE),
    .WIN_LOG2    (WIN_LOG2),
    .COMMON_BASE (COMMON_BASE),
    .COMMON_LOG2 (COMMON_LOG2)
  ) dec_i (
    .mem_req  (mem_req),
    .cpu_addr (cpu_addr),
    .rom_off  (bank_q.rom_off),
    .target   (target)
  );

  assign sys_addr  = {1'b0, bank_q.ext, cpu_addr};
  assign rom_cs    = (target == TGT_ROM);
  assign sram_cs   = (target == TGT_SRAM);
  assign common_cs = (target == TGT_COMMON);
  assign banked_cs = (target == TGT_BANKED);
endmodule

// File: rtl/bank_map_ctrl_chk.sv
module bank_map_ctrl_chk #(
  parameter logic [7:0] PORT_ADDR = 8'h40
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        mem_req,
  input logic        io_wr,
  input logic [7:0]  io_data,
  input logic [23:0] sys_addr,
  input logic        rom_cs,
  input logic        sram_cs,
  input logic        common_cs,
  input logic        banked_cs
);
  // R4
  a23_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_addr[23] == 1'b0);

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $onehot({rom_cs, sram_cs, common_cs, banked_cs}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> ({rom_cs, sram_cs, common_cs, banked_cs} == 4'b0000));

  // R9
  common_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_addr[15:14] == 2'b11) |-> !banked_cs);

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && cpu_addr[7:0] == PORT_ADDR) |=> $stable(sys_addr[22:16]));

  // R3
  low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_addr[15:0] == cpu_addr);
endmodule

bind bank_map_ctrl bank_map_ctrl_chk #(.PORT_ADDR(PORT_ADDR)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .mem_req   (mem_req),
  .io_wr     (io_wr),
  .io_data   (io_data),
  .sys_addr  (sys_addr),
  .rom_cs    (rom_cs),
  .sram_cs   (sram_cs),
  .common_cs (common_cs),
  .banked_cs (banked_cs)
);

// File: tb/bank_map_ctrl_tb_top.sv
module bank_map_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_req;
  logic        io_wr;
  logic [7:0]  io_data;
  logic [23:0] sys_addr;
  logic        rom_cs, sram_cs, common_cs, banked_cs;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bank_map_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .io_wr(io_wr), .io_data(io_data), .sys_addr(sys_addr),
    .rom_cs(rom_cs), .sram_cs(sram_cs), .common_cs(common_cs), .banked_cs(banked_cs)
  );

  // select code: 1 rom, 2 sram, 3 common, 4 banked, 0 none, 9 several
  function automatic int sel_code();
    int n = int'(rom_cs) + int'(sram_cs) + int'(common_cs) + int'(banked_cs);
    if (n > 1) return 9;
    if (rom_cs) return 1;
    if (sram_cs) return 2;
    if (common_cs) return 3;
    if (banked_cs) return 4;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_port(logic [7:0] port, logic [7:0] val);
    @(negedge clk);
    mem_req = 1'b0; io_wr = 1'b1; cpu_addr = {8'h00, port}; io_data = val;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic probe(logic [15:0] a, logic rq);
    @(negedge clk);
    cpu_addr = a; mem_req = rq;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", int'(sys_addr[22:16]), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    probe(16'hF000, 1'b1);
    chk("R1 rom after reset", sel_code(), 1);
    chk("R1 bank zero", int'(sys_addr[22:16]), 0);
    write_port(8'h40, 8'hA5);
    do_reset();
    probe(16'hF000, 1'b1);
    chk("R1 rom after second reset", sel_code(), 1);
    chk("R1 bank cleared", int'(sys_addr[22:16]), 0);
  endtask

  task automatic t_bank();
    write_port(8'h40, 8'h15);
    probe(16'h1234, 1'b1);
    chk("R3 sys_addr", int'(sys_addr), 24'h151234);
    chk("R10 banked", sel_code(), 4);
    write_port(8'h41, 8'h33);
    probe(16'h1234, 1'b1);
    chk("R2 other port ignored", int'(sys_addr), 24'h151234);
    write_port(8'h40, 8'h7F);
    probe(16'hBFFF, 1'b1);
    chk("R3 max bank", int'(sys_addr), 24'h7FBFFF);
    chk("R10 edge below common", sel_code(), 4);
  endtask

  task automatic t_rom_dis();
    write_port(8'h40, 8'h80);
    probe(16'hF000, 1'b1);
    chk("R6 rom off fetch", sel_code(), 3);
    chk("R4 a23 low", int'(sys_addr[23]), 0);
    probe(16'hF400, 1'b1);
    chk("R7 sram off", sel_code(), 3);
    write_port(8'h40, 8'hFF);
    probe(16'hF3FF, 1'b1);
    chk("R4 a23 low full reg", int'(sys_addr), 24'h7FF3FF);
    chk("R6 rom off end", sel_code(), 3);
    write_port(8'h40, 8'h00);
    probe(16'hF3FF, 1'b1);
    chk("R5 rom end", sel_code(), 1);
    probe(16'hF400, 1'b1);
    chk("R8 sram start", sel_code(), 2);
    probe(16'hF7FF, 1'b1);
    chk("R7 sram end", sel_code(), 2);
    probe(16'hF800, 1'b1);
    chk("R9 above sram", sel_code(), 3);
    probe(16'hEFFF, 1'b1);
    chk("R9 below rom", sel_code(), 3);
  endtask

  task automatic t_common();
    for (int b = 0; b < 128; b += 9) begin
      write_port(8'h40, 8'(b));
      probe(16'hC000, 1'b1);
      chk("R9 common start", sel_code(), 3);
      probe(16'hFFFF, 1'b1);
      chk("R9 common top", sel_code(), 3);
      probe(16'hF000, 1'b1);
      chk("R9 rom inside common", sel_code(), 1);
      probe(16'h8000, 1'b1);
      chk("R10 banked", sel_code(), 4);
    end
  endtask

  task automatic t_idle();
    write_port(8'h40, 8'h00);
    probe(16'hF000, 1'b0);
    chk("R11 idle rom addr", sel_code(), 0);
    probe(16'h0100, 1'b0);
    chk("R11 idle low addr", sel_code(), 0);
    @(negedge clk);
    io_wr = 1'b1; cpu_addr = 16'h0041; io_data = 8'h01; mem_req = 1'b0;
    #1;
    chk("R11 io cycle", sel_code(), 0);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; mem_req = 1'b0; io_wr = 1'b0; io_data = '0;
    t_reset();
    t_bank();
    t_rom_dis();
    t_common();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule